// File: doc/BRIEF.md
# SPI Instruction Stream Sequencer

This block is the control core of an SPI master. It takes 16-bit instructions, one at a time, from a command queue and carries them out in order. The instructions drive eight chip-select lines, set the shift clock divider, the mode and the word length, time pauses in shift-clock periods, start word bursts on an attached bit shifter, and post synchronisation markers. Software builds a whole message as an instruction list. It ends the list with a sync marker and waits for the matching interrupt.

Every instruction has the same field layout: opcode in bits 15:12, first argument in bits 11:8 and second argument in bits 7:0. The sequencer has four states. In ST_IDLE it pops an instruction when one is offered. It then spends one cycle in ST_EXEC decoding and acting on it. A transfer moves it to ST_BURST until the shifter reports completion. A sleep or a chip-select update moves it to ST_WAIT until the delay timer reaches zero. Every other instruction returns it straight to ST_IDLE. A hold input forces ST_IDLE from any state. ST_BURST and ST_WAIT also return to ST_IDLE on their own exit conditions.

One shift-clock period lasts P = 2*(clk_div+1) clock cycles.

Top module: `spi_seq_top`

## Requirements
- R1: When idle and not held, the sequencer asserts cmd_ready and pops a valid instruction on that clock edge. It spends exactly one cycle in ST_EXEC and pops nothing during that cycle.
- R2: Opcode 0 (transfer) raises burst_start for exactly the ST_EXEC cycle, with burst_flags = bits 11:8 and burst_words_m1 = bits 7:0. The sequencer then stays in ST_BURST until burst_done is sampled high.
- R3: Opcode 1 (chip-select update) waits d*P+1 cycles in ST_WAIT, where d = bits 11:8. It then sets cs_n to bits 7:0 XOR the active inversion mask. A 0 bit in the argument selects that line. After reset cs_n is 8'hFF.
- R4: Opcode 4 loads bits 7:0 as a pending inversion mask. The pins keep their value until the next chip-select update completes, which copies the pending mask into the active mask.
- R5: Opcode 2 writes bits 7:0 into the register picked by bits 11:8: 0 is clk_div, 1 is mode_cfg, 2 is word_bits. Any other select is ignored. The reset values are 0, 0 and 8.
- R6: Opcode 3 with bits 11:8 = 1 (sleep) stays in ST_WAIT for exactly (n+1)*P cycles, where n = bits 7:0.
- R7: Opcode 3 with bits 11:8 = 0 (sync) pulses sync_strobe for one cycle, loads sync_id with bits 7:0 and sets irq_pend[3].
- R8: irq_pend[0], [1] and [2] are set in every cycle that cmd_low, tx_low and rx_high, respectively, are high. Writing 1 on irq_clr clears a pending bit, but a set in the same cycle wins. irq is the OR of irq_pend AND irq_en.
- R9: While hold is high, cmd_ready and burst_start stay low. From the next cycle the state is ST_IDLE and cs_n shows every line inactive (all-ones XOR the active mask). An instruction in progress is abandoned.
- R10: Opcodes 5 to 15 and the sub-codes 2 to 15 of opcode 3 are consumed in one ST_EXEC cycle with no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold | input | 1 | Soft reset: keeps the sequencer idle with every chip select inactive |
| cmd_valid | input | 1 | An instruction is offered |
| cmd_data | input | 16 | Offered instruction |
| cmd_ready | output | 1 | Instruction is popped on this edge when cmd_valid is high |
| burst_start | output | 1 | Starts a shifter burst |
| burst_flags | output | 4 | Read/write flags of the burst |
| burst_words_m1 | output | 8 | Word count minus one |
| burst_done | input | 1 | Shifter finished the burst |
| cs_n | output | 8 | Chip-select lines |
| clk_div | output | 8 | Shift clock divider |
| mode_cfg | output | 8 | Clock polarity, phase and wiring mode bits |
| word_bits | output | 8 | Bits per word |
| sync_strobe | output | 1 | One-cycle sync marker |
| sync_id | output | 8 | Identifier of the last sync |
| cmd_low | input | 1 | Command queue almost empty |
| tx_low | input | 1 | Transmit queue almost empty |
| rx_high | input | 1 | Receive queue almost full |
| irq_clr | input | 4 | Write-one-to-clear strobes for irq_pend |
| irq_en | input | 4 | Interrupt enables |
| irq_pend | output | 4 | Pending interrupt bits |
| irq | output | 1 | Interrupt request |

## Verification
The first instruction stream runs with a divider of 0. It mixes register writes, an ignored register select, an inversion load followed by updates, a burst, a sleep, undefined opcodes and a sync. This shows whether the inversion is deferred and whether ignored instructions leak into the outputs. The second stream reruns sleeps and delayed updates with a divider of 2, which separates a delay scaled by the period from one counted in raw cycles. Hold is then raised in the middle of a long sleep and again in the middle of a delayed update, which shows whether the pending work is dropped. The queue-level inputs are pulsed while clears are written, so the case where a set and a clear land in the same cycle is covered.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
    localparam int INSTR_W = 16;
    localparam int OPC_W   = 4;
    localparam int ARG1_W  = 4;
    localparam int ARG2_W  = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EXEC  = 2'd1,
        ST_BURST = 2'd2,
        ST_WAIT  = 2'd3
    } seq_state_e;

    localparam logic [OPC_W-1:0] OPC_XFER  = 4'd0;
    localparam logic [OPC_W-1:0] OPC_CS    = 4'd1;
    localparam logic [OPC_W-1:0] OPC_WREG  = 4'd2;
    localparam logic [OPC_W-1:0] OPC_MISC  = 4'd3;
    localparam logic [OPC_W-1:0] OPC_CSINV = 4'd4;

    localparam logic [ARG1_W-1:0] MISC_SYNC  = 4'd0;
    localparam logic [ARG1_W-1:0] MISC_SLEEP = 4'd1;

    localparam logic [ARG1_W-1:0] REG_DIV  = 4'd0;
    localparam logic [ARG1_W-1:0] REG_MODE = 4'd1;
    localparam logic [ARG1_W-1:0] REG_BITS = 4'd2;
endpackage

// File: rtl/seq_delay_timer.sv
module seq_delay_timer #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/seq_cfg_regs.sv
module seq_cfg_regs
    import spi_seq_pkg::*;
#(
    parameter int VAL_W    = 8,
    parameter int BITS_RST = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ARG1_W-1:0] wr_sel,
    input  logic [VAL_W-1:0]  wr_val,
    output logic [VAL_W-1:0]  div_o,
    output logic [VAL_W-1:0]  mode_o,
    output logic [VAL_W-1:0]  bits_o
);
    localparam int NREG = 3;
    logic [VAL_W-1:0] regs_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [VAL_W-1:0] RST_V = (g == int'(REG_BITS)) ? VAL_W'(BITS_RST) : '0;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[g] <= RST_V;
            end else if (wr_en && (wr_sel == ARG1_W'(g))) begin
                regs_q[g] <= wr_val;
            end
        end
    end

    assign div_o  = regs_q[int'(REG_DIV)];
    assign mode_o = regs_q[int'(REG_MODE)];
    assign bits_o = regs_q[int'(REG_BITS)];
endmodule

// File: rtl/seq_cs_ctrl.sv
module seq_cs_ctrl #(
    parameter int LINES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             force_off,
    input  logic             inv_load,
    input  logic [LINES-1:0] inv_val,
    input  logic             apply,
    input  logic [LINES-1:0] sel_val,
    output logic [LINES-1:0] cs_n
);
    logic [LINES-1:0] sel_q;
    logic [LINES-1:0] inv_pend_q;
    logic [LINES-1:0] inv_act_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q      <= '1;
            inv_pend_q <= '0;
            inv_act_q  <= '0;
        end else begin
            if (inv_load) begin
                inv_pend_q <= inv_val;
            end
            if (force_off) begin
                sel_q <= '1;
            end else if (apply) begin
                sel_q     <= sel_val;
                inv_act_q <= inv_pend_q;
            end
        end
    end

    assign cs_n = sel_q ^ inv_act_q;
endmodule

// File: rtl/seq_irq_ctrl.sv
module seq_irq_ctrl #(
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] clr_i,
    input  logic [NSRC-1:0] en_i,
    output logic [NSRC-1:0] pend_o,
    output logic            irq_o
);
    logic [NSRC-1:0] pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_i) | set_i;
        end
    end

    assign pend_o = pend_q;
    assign irq_o  = |(pend_q & en_i);
endmodule

// File: rtl/spi_seq_top.sv
module spi_seq_top
    import spi_seq_pkg::*;
#(
    parameter int CS_LINES = 8,
    parameter int BITS_RST = 8,
    parameter int NIRQ     = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hold,
    input  logic                cmd_valid,
    input  logic [INSTR_W-1:0]  cmd_data,
    output logic                cmd_ready,
    output logic                burst_start,
    output logic [ARG1_W-1:0]   burst_flags,
    output logic [ARG2_W-1:0]   burst_words_m1,
    input  logic                burst_done,
    output logic [CS_LINES-1:0] cs_n,
    output logic [ARG2_W-1:0]   clk_div,
    output logic [ARG2_W-1:0]   mode_cfg,
    output logic [ARG2_W-1:0]   word_bits,
    output logic                sync_strobe,
    output logic [ARG2_W-1:0]   sync_id,
    input  logic                cmd_low,
    input  logic                tx_low,
    input  logic                rx_high,
    input  logic [NIRQ-1:0]     irq_clr,
    input  logic [NIRQ-1:0]     irq_en,
    output logic [NIRQ-1:0]     irq_pend,
    output logic                irq
);
    // Delay count width: (max arg2 + 1) * 2 * (max divider + 1)
    localparam int TMR_W = 2 * ARG2_W + 2;

    seq_state_e           state_q, state_d;
    logic [INSTR_W-1:0]   ir_q;
    logic [OPC_W-1:0]     opc;
    logic [ARG1_W-1:0]    arg1;
    logic [ARG2_W-1:0]    arg2;
    logic                 exec_act;
    logic                 is_sleep;
    logic                 reg_wr;
    logic                 inv_ld;
    logic                 tmr_ld;
    logic [TMR_W-1:0]     tmr_val;
    logic [TMR_W-1:0]     period;
    logic                 tmr_zero;
    logic                 cs_apply;
    logic [ARG2_W-1:0]    sync_id_q;
    logic [NIRQ-1:0]      irq_set;

    assign opc  = ir_q[INSTR_W-1 -: OPC_W];
    assign arg1 = ir_q[ARG2_W +: ARG1_W];
    assign arg2 = ir_q[ARG2_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ir_q      <= '0;
            sync_id_q <= '0;
        end else begin
            if (cmd_ready && cmd_valid) begin
                ir_q <= cmd_data;
            end
            if (sync_strobe) begin
                sync_id_q <= arg2;
            end
        end
    end

    assign is_sleep = (opc == OPC_MISC) && (arg1 == MISC_SLEEP);

    always_comb begin
        state_d = state_q;
        if (hold) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (cmd_valid) state_d = ST_EXEC;
                ST_EXEC: begin
                    if (opc == OPC_XFER) begin
                        state_d = ST_BURST;
                    end else if ((opc == OPC_CS) || is_sleep) begin
                        state_d = ST_WAIT;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
                ST_BURST: if (burst_done) state_d = ST_IDLE;
                ST_WAIT:  if (tmr_zero) state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        period      = (TMR_W'(clk_div) + TMR_W'(1)) << 1;
        cmd_ready   = !hold && (state_q == ST_IDLE);
        exec_act    = !hold && (state_q == ST_EXEC);
        burst_start = exec_act && (opc == OPC_XFER);
        sync_strobe = exec_act && (opc == OPC_MISC) && (arg1 == MISC_SYNC);
        reg_wr      = exec_act && (opc == OPC_WREG);
        inv_ld      = exec_act && (opc == OPC_CSINV);
        tmr_ld      = hold || (exec_act && ((opc == OPC_CS) || is_sleep));
        if (hold) begin
            tmr_val = '0;
        end else if (opc == OPC_CS) begin
            tmr_val = TMR_W'(arg1) * period;
        end else begin
            tmr_val = (TMR_W'(arg2) + TMR_W'(1)) * period - TMR_W'(1);
        end
        cs_apply    = !hold && (state_q == ST_WAIT) && tmr_zero && (opc == OPC_CS);
    end

    assign burst_flags    = arg1;
    assign burst_words_m1 = arg2;
    assign sync_id        = sync_id_q;
    assign irq_set        = {sync_strobe, rx_high, tx_low, cmd_low};

    seq_delay_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_ld),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    seq_cfg_regs #(.VAL_W(ARG2_W), .BITS_RST(BITS_RST)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr),
        .wr_sel (arg1),
        .wr_val (arg2),
        .div_o  (clk_div),
        .mode_o (mode_cfg),
        .bits_o (word_bits)
    );

    seq_cs_ctrl #(.LINES(CS_LINES)) u_cs (
        .clk       (clk),
        .rst_n     (rst_n),
        .force_off (hold),
        .inv_load  (inv_ld),
        .inv_val   (arg2[CS_LINES-1:0]),
        .apply     (cs_apply),
        .sel_val   (arg2[CS_LINES-1:0]),
        .cs_n      (cs_n)
    );

    seq_irq_ctrl #(.NSRC(NIRQ)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (irq_set),
        .clr_i  (irq_clr),
        .en_i   (irq_en),
        .pend_o (irq_pend),
        .irq_o  (irq)
    );
endmodule

// File: rtl/spi_seq_chk.sv
module spi_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       hold,
    input logic       cmd_valid,
    input logic       cmd_ready,
    input logic [1:0] state_q,
    input logic       burst_start,
    input logic       burst_done,
    input logic       sync_strobe,
    input logic       cs_apply,
    input logic [7:0] cs_n,
    input logic [3:0] irq_pend
);
    localparam logic [1:0] S_IDLE  = 2'd0;
    localparam logic [1:0] S_BURST = 2'd2;

    // R1: a pop is followed by a cycle in which nothing is popped
    p_single_pop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    // R2: the sequencer stays in the burst state until the shifter reports done
    p_burst_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BURST && !burst_done && !hold) |=> (state_q == S_BURST));

    // R4: the pins only move on a completed update or under hold
    p_pins_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_apply && !hold) |=> $stable(cs_n));

    // R7: a sync marker leaves its pending bit set
    p_sync_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sync_strobe |=> irq_pend[3]);

    // R9: hold returns the sequencer to idle
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (state_q == S_IDLE));

    // R10: at most one action is taken per cycle
    p_one_action_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({burst_start, sync_strobe, cs_apply}));
endmodule

bind spi_seq_top spi_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hold        (hold),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .state_q     (state_q),
    .burst_start (burst_start),
    .burst_done  (burst_done),
    .sync_strobe (sync_strobe),
    .cs_apply    (cs_apply),
    .cs_n        (cs_n),
    .irq_pend    (irq_pend)
);

// File: tb/spi_seq_top_test.sv
module spi_seq_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hold = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [15:0] cmd_data = '0;
    logic        cmd_ready;
    logic        burst_start;
    logic [3:0]  burst_flags;
    logic [7:0]  burst_words_m1;
    logic        burst_done = 1'b0;
    logic [7:0]  cs_n;
    logic [7:0]  clk_div;
    logic [7:0]  mode_cfg;
    logic [7:0]  word_bits;
    logic        sync_strobe;
    logic [7:0]  sync_id;
    logic        cmd_low = 1'b0;
    logic        tx_low = 1'b0;
    logic        rx_high = 1'b0;
    logic [3:0]  irq_clr = '0;
    logic [3:0]  irq_en = '0;
    logic [3:0]  irq_pend;
    logic        irq;

    spi_seq_top uut (
        .clk(clk), .rst_n(rst_n), .hold(hold),
        .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_ready(cmd_ready),
        .burst_start(burst_start), .burst_flags(burst_flags),
        .burst_words_m1(burst_words_m1), .burst_done(burst_done),
        .cs_n(cs_n), .clk_div(clk_div), .mode_cfg(mode_cfg), .word_bits(word_bits),
        .sync_strobe(sync_strobe), .sync_id(sync_id),
        .cmd_low(cmd_low), .tx_low(tx_low), .rx_high(rx_high),
        .irq_clr(irq_clr), .irq_en(irq_en), .irq_pend(irq_pend), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit started = 0;
    bit finished = 0;

    // Instruction queue feeding the block
    logic [15:0] cmdq[$];

    // Reference model: 0 idle, 1 exec, 2 burst, 3 wait
    int          m_st = 0;
    logic [15:0] m_ir = '0;
    logic [7:0]  m_sel = 8'hFF;
    logic [7:0]  m_invp = '0;
    logic [7:0]  m_inva = '0;
    logic [7:0]  m_div = '0;
    logic [7:0]  m_mode = '0;
    logic [7:0]  m_bits = 8'd8;
    logic [7:0]  m_sid = '0;
    logic [3:0]  m_pend = '0;
    int          m_tmr = 0;
    int          shf_cnt = 0;

    function automatic int opc_of(logic [15:0] w); return int'(w[15:12]); endfunction
    function automatic int a1_of(logic [15:0] w);  return int'(w[11:8]);  endfunction
    function automatic int a2_of(logic [15:0] w);  return int'(w[7:0]);   endfunction

    function automatic bit exp_exec();
        return !hold && (m_st == 1);
    endfunction
    function automatic bit exp_burst();
        return exp_exec() && opc_of(m_ir) == 0;
    endfunction
    function automatic bit exp_sync();
        return exp_exec() && opc_of(m_ir) == 3 && a1_of(m_ir) == 0;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_st = 0; m_ir = '0; m_sel = 8'hFF; m_invp = '0; m_inva = '0;
            m_div = '0; m_mode = '0; m_bits = 8'd8; m_sid = '0; m_pend = '0; m_tmr = 0;
        end else begin
            int per;
            bit sy;
            per = 2 * (int'(m_div) + 1);
            sy = exp_sync();
            m_pend = (m_pend & ~irq_clr) | {sy, rx_high, tx_low, cmd_low};
            if (hold) begin
                m_st = 0; m_sel = 8'hFF; m_tmr = 0;
            end else begin
                case (m_st)
                    0: if (cmd_valid) begin
                        m_ir = cmd_data;
                        void'(cmdq.pop_front());
                        m_st = 1;
                    end
                    1: begin
                        m_st = 0;
                        case (opc_of(m_ir))
                            0: begin m_st = 2; shf_cnt = 3; end
                            1: begin m_tmr = a1_of(m_ir) * per; m_st = 3; end
                            2: case (a1_of(m_ir))
                                   0: m_div  = m_ir[7:0];
                                   1: m_mode = m_ir[7:0];
                                   2: m_bits = m_ir[7:0];
                                   default: ;
                               endcase
                            3: if (a1_of(m_ir) == 0) m_sid = m_ir[7:0];
                               else if (a1_of(m_ir) == 1) begin
                                   m_tmr = (a2_of(m_ir) + 1) * per - 1; m_st = 3;
                               end
                            4: m_invp = m_ir[7:0];
                            default: ;
                        endcase
                    end
                    2: if (burst_done) m_st = 0;
                    default: if (m_tmr == 0) begin
                        if (opc_of(m_ir) == 1) begin
                            m_sel = m_ir[7:0]; m_inva = m_invp;
                        end
                        m_st = 0;
                    end else m_tmr--;
                endcase
            end
        end
        started = 1;
    end

    // Input drivers, away from the active edge
    always @(posedge clk) begin
        #1;
        cmd_valid = (cmdq.size() > 0);
        cmd_data  = (cmdq.size() > 0) ? cmdq[0] : 16'h0;
        burst_done = (shf_cnt == 1);
        if (shf_cnt > 0) shf_cnt--;
    end

    task automatic chk(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started && !finished) begin
            chk("R1 cmd_ready", int'(cmd_ready), int'(!hold && m_st == 0));
            chk("R2 burst_start", int'(burst_start), int'(exp_burst()));
            if (exp_burst()) begin
                chk("R2 burst_flags", int'(burst_flags), a1_of(m_ir));
                chk("R2 burst_words_m1", int'(burst_words_m1), a2_of(m_ir));
            end
            chk("R3 R4 R9 cs_n", int'(cs_n), int'(m_sel ^ m_inva));
            chk("R5 clk_div", int'(clk_div), int'(m_div));
            chk("R5 mode_cfg", int'(mode_cfg), int'(m_mode));
            chk("R5 word_bits", int'(word_bits), int'(m_bits));
            chk("R7 sync_strobe", int'(sync_strobe), int'(exp_sync()));
            chk("R7 sync_id", int'(sync_id), int'(m_sid));
            chk("R8 irq_pend", int'(irq_pend), int'(m_pend));
            chk("R8 irq", int'(irq), int'(|(m_pend & irq_en)));
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic drain();
        int guard = 0;
        while ((cmdq.size() > 0 || m_st != 0 || cmd_valid) && guard < 5000) begin
            step(1);
            guard++;
        end
        step(3);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        if (cycles > WATCHDOG) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got %0d expected %0d cycles at most", cycles, WATCHDOG);
            finish_run();
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        irq_en = 4'hF;
        step(2);
        // R5 R4 R3 R2 R6 R10 R7 with divider 0
        cmdq.push_back(16'h2000);
        cmdq.push_back(16'h2103);
        cmdq.push_back(16'h2210);
        cmdq.push_back(16'h2507);   // R10 ignored select
        cmdq.push_back(16'h4004);   // R4 pending only
        cmdq.push_back(16'h10FE);
        cmdq.push_back(16'h0305);
        cmdq.push_back(16'h3103);
        cmdq.push_back(16'h12FF);
        cmdq.push_back(16'h7ABC);   // R10 undefined opcode
        cmdq.push_back(16'h3512);   // R10 undefined sub-code
        cmdq.push_back(16'h305A);
        drain();
        irq_clr = 4'h8;
        step(1);
        irq_clr = 4'h0;
        // R6 R3 with divider 2
        cmdq.push_back(16'h2002);
        cmdq.push_back(16'h310A);
        cmdq.push_back(16'h11EF);
        cmdq.push_back(16'h0AFF);
        cmdq.push_back(16'h3001);
        cmdq.push_back(16'h4000);
        cmdq.push_back(16'h10FF);
        cmdq.push_back(16'h2000);
        drain();
        // R8 level sources, set wins over clear
        cmd_low = 1'b1; step(1); cmd_low = 1'b0;
        tx_low = 1'b1; irq_clr = 4'h3; step(1); irq_clr = 4'h0; tx_low = 1'b0;
        rx_high = 1'b1; step(2); rx_high = 1'b0;
        irq_en = 4'h2; step(1);
        irq_clr = 4'hF; step(1); irq_clr = 4'h0; step(2);
        irq_en = 4'hF;
        // R9 hold during a long sleep and during a delayed update
        cmdq.push_back(16'h4080);
        cmdq.push_back(16'h10F0);
        cmdq.push_back(16'h31FF);
        cmdq.push_back(16'h10AA);
        cmdq.push_back(16'h3077);
        step(40);
        hold = 1'b1; step(4); hold = 1'b0;
        step(3);
        hold = 1'b1; step(2); hold = 1'b0;
        drain();
        cmdq.push_back(16'h1F3C);
        step(8);
        hold = 1'b1; step(3); hold = 1'b0;
        drain();
        finish_run();
    end
endmodule